// File: doc/BRIEF.md
# Framed Packet Builder and Checker

This block connects a node's local memory port to a router link made of 32-bit words, and has one half for each direction. The transmit half takes a 32-bit header descriptor and a destination address through a single handshake. It then pulls N payload words from a local stream and sends a framed packet on the link. The frame is a start keyword, the header word, the address word, the payload, a checksum word and an end keyword. The receive half searches the incoming link stream for the start keyword. It captures the header and address, passes the payload to a local stream and verifies the checksum and the end keyword. For each frame it gives one completion pulse that carries the error flags.

Every port that moves words uses valid/ready handshaking, and a stall on either side holds the current word. The header word carries a 2-bit kind, which selects plain data, a transfer instruction in the payload, or an acknowledgement. The block does not interpret the kind. It uses only the length field and the check-enable bit.

Top module: `pkt_link_codec`

## Requirements
- R1: The transmitter emits words in this order: start keyword HDR_KEY (default 0xA5C30F1E), header word, address word, N payload words in arrival order, checksum, end keyword TRL_KEY (default 0xE1F03C5A). The header descriptor is accepted only while the transmitter is idle.
- R2: The checksum word is the sum modulo 2^32 of the header word, the address word and every payload word.
- R3: The header word is sent unchanged, with this layout: kind [31:30], priority [29:28], source id [27:24], destination id [23:20], data format [19:18], data type [17:16], protocol number [15:14], protocol revision [13], check enable [12], packet index X [11:10], packet total Y [9:8], payload length N [7:0].
- R4: When N = 0, the checksum word follows the address word directly in both directions.
- R5: On the link output, a word offered without ready stays offered and unchanged in the next cycle. A payload stall on the local side of either half passes through as backpressure, and no word is lost.
- R6: The receiver discards every word until it sees HDR_KEY, and discarded words produce no output.
- R7: After the address word is accepted, the receiver shows the header and address with a one-cycle strobe and then forwards the N payload words in order.
- R8: If check enable is 1 and the received checksum differs from the computed sum, the receiver pulses done with sum_err. It then searches for HDR_KEY again without waiting for an end keyword.
- R9: If check enable is 0, the checksum word is not compared.
- R10: If the word after the checksum is not TRL_KEY, the receiver pulses done with frame_err. A correct frame pulses done with both error flags low.
- R11: After reset the transmitter offers nothing and accepts a header, the receiver accepts link words, and no strobe, done or payload is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_hdr_i | input | 32 | Header word to send |
| tx_addr_i | input | 32 | Destination address word to send |
| tx_hdr_valid_i | input | 1 | Header descriptor valid |
| tx_hdr_ready_o | output | 1 | Transmitter idle, descriptor accepted |
| tx_pl_data_i | input | 32 | Local payload word |
| tx_pl_valid_i | input | 1 | Local payload valid |
| tx_pl_ready_o | output | 1 | Local payload accepted |
| link_tx_data_o | output | 32 | Link output word |
| link_tx_valid_o | output | 1 | Link output valid |
| link_tx_ready_i | input | 1 | Link output ready |
| link_rx_data_i | input | 32 | Link input word |
| link_rx_valid_i | input | 1 | Link input valid |
| link_rx_ready_o | output | 1 | Link input accepted |
| rx_hdr_o | output | 32 | Last received header word |
| rx_addr_o | output | 32 | Last received address word |
| rx_hdr_strobe_o | output | 1 | One-cycle pulse: header and address updated |
| rx_pl_data_o | output | 32 | Received payload word |
| rx_pl_valid_o | output | 1 | Received payload valid |
| rx_pl_ready_i | input | 1 | Local sink ready |
| rx_done_o | output | 1 | One-cycle end-of-frame pulse |
| rx_sum_err_o | output | 1 | Checksum mismatch, valid with done |
| rx_frame_err_o | output | 1 | End keyword missing, valid with done |

## Verification
The bench builds the block with its default keys and with the 8-bit length field. It uses lengths 0, 1, 4, 5 and 12, which reach the empty-payload path, the single-word payload and several transitions from payload to checksum. Pseudo-random ready patterns on the link output and on the local payload sink, together with idle gaps in both sources, force stalls on every kind of word. The receive streams put junk ahead of frames and include a corrupted checksum with checking enabled, the same corruption with checking disabled, and a wrong end keyword. A clean frame follows the checksum failure to confirm that the receiver returns to searching.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 8;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_XFER = 2'd1,
    KIND_ACK  = 2'd2,
    KIND_RSVD = 2'd3
  } pkt_kind_e;

  typedef struct packed {
    logic [1:0]       kind;
    logic [1:0]       prio;
    logic [3:0]       src_id;
    logic [3:0]       dst_id;
    logic [1:0]       fmt;
    logic [1:0]       dtype;
    logic [1:0]       proto;
    logic             rev;
    logic             chk_en;
    logic [1:0]       seq_x;
    logic [1:0]       seq_y;
    logic [LEN_W-1:0] len;
  } hdr_t;
endpackage

// File: rtl/pkt_tx.sv
module pkt_tx
  import pkt_pkg::*;
#(
  parameter logic [WORD_W-1:0] HDR_KEY = 32'hA5C3_0F1E,
  parameter logic [WORD_W-1:0] TRL_KEY = 32'hE1F0_3C5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] hdr_i,
  input  logic [WORD_W-1:0] addr_i,
  input  logic              hdr_valid_i,
  output logic              hdr_ready_o,
  input  logic [WORD_W-1:0] pl_data_i,
  input  logic              pl_valid_i,
  output logic              pl_ready_o,
  output logic [WORD_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i
);
  typedef enum logic [2:0] {
    T_IDLE, T_KEY, T_TYPE, T_ADDR, T_PAY, T_SUM, T_TRL
  } tx_state_e;

  tx_state_e         st_q;
  logic [WORD_W-1:0] type_q, addr_q, sum_q;
  logic [LEN_W-1:0]  left_q;
  logic              fire;

  assign fire        = tx_valid_o && tx_ready_i;
  assign hdr_ready_o = (st_q == T_IDLE);

  always_comb begin
    tx_valid_o = 1'b1;
    tx_data_o  = '0;
    pl_ready_o = 1'b0;
    unique case (st_q)
      T_IDLE: tx_valid_o = 1'b0;
      T_KEY:  tx_data_o  = HDR_KEY;
      T_TYPE: tx_data_o  = type_q;
      T_ADDR: tx_data_o  = addr_q;
      T_PAY: begin
        tx_data_o  = pl_data_i;
        tx_valid_o = pl_valid_i;
        pl_ready_o = tx_ready_i;
      end
      T_SUM:  tx_data_o  = sum_q;
      T_TRL:  tx_data_o  = TRL_KEY;
      default: tx_valid_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= T_IDLE;
      type_q <= '0;
      addr_q <= '0;
      sum_q  <= '0;
      left_q <= '0;
    end else begin
      unique case (st_q)
        T_IDLE: if (hdr_valid_i) begin
          type_q <= hdr_i;
          addr_q <= addr_i;
          left_q <= hdr_i[LEN_W-1:0];
          sum_q  <= '0;
          st_q   <= T_KEY;
        end
        T_KEY:  if (fire) st_q <= T_TYPE;
        T_TYPE: if (fire) begin
          sum_q <= sum_q + type_q;
          st_q  <= T_ADDR;
        end
        T_ADDR: if (fire) begin
          sum_q <= sum_q + addr_q;
          st_q  <= (left_q == '0) ? T_SUM : T_PAY;
        end
        T_PAY: if (fire) begin
          sum_q  <= sum_q + pl_data_i;
          left_q <= left_q - 1'b1;
          if (left_q == LEN_W'(1)) st_q <= T_SUM;
        end
        T_SUM:  if (fire) st_q <= T_TRL;
        T_TRL:  if (fire) st_q <= T_IDLE;
        default: st_q <= T_IDLE;
      endcase
    end
  end

  // R5: non-payload words are held under stall
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && st_q != T_PAY) |=> (tx_valid_o && $stable(tx_data_o)));

  // R1: an accepted descriptor leads with the start keyword
  p_key_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && hdr_ready_o) |=> (tx_valid_o && tx_data_o == HDR_KEY));

  // R1: no new descriptor while a frame is in flight
  p_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && hdr_ready_o) |=> !hdr_ready_o);
endmodule

// File: rtl/pkt_rx.sv
module pkt_rx
  import pkt_pkg::*;
#(
  parameter logic [WORD_W-1:0] HDR_KEY = 32'hA5C3_0F1E,
  parameter logic [WORD_W-1:0] TRL_KEY = 32'hE1F0_3C5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic [WORD_W-1:0] hdr_o,
  output logic [WORD_W-1:0] addr_o,
  output logic              hdr_strobe_o,
  output logic [WORD_W-1:0] pl_data_o,
  output logic              pl_valid_o,
  input  logic              pl_ready_i,
  output logic              done_o,
  output logic              sum_err_o,
  output logic              frame_err_o
);
  typedef enum logic [2:0] {
    R_HUNT, R_TYPE, R_ADDR, R_PAY, R_SUM, R_TRL
  } rx_state_e;

  rx_state_e         st_q;
  hdr_t              hdr_q;
  logic [WORD_W-1:0] addr_q, sum_q;
  logic [LEN_W-1:0]  left_q;
  logic              strobe_q, done_q, serr_q, ferr_q;
  logic              fire;

  assign rx_ready_o   = (st_q == R_PAY) ? pl_ready_i : 1'b1;
  assign pl_valid_o   = (st_q == R_PAY) && rx_valid_i;
  assign pl_data_o    = rx_data_i;
  assign fire         = rx_valid_i && rx_ready_o;
  assign hdr_o        = hdr_q;
  assign addr_o       = addr_q;
  assign hdr_strobe_o = strobe_q;
  assign done_o       = done_q;
  assign sum_err_o    = serr_q;
  assign frame_err_o  = ferr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= R_HUNT;
      hdr_q    <= '0;
      addr_q   <= '0;
      sum_q    <= '0;
      left_q   <= '0;
      strobe_q <= 1'b0;
      done_q   <= 1'b0;
      serr_q   <= 1'b0;
      ferr_q   <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      done_q   <= 1'b0;
      serr_q   <= 1'b0;
      ferr_q   <= 1'b0;
      if (fire) begin
        unique case (st_q)
          R_HUNT: if (rx_data_i == HDR_KEY) st_q <= R_TYPE;
          R_TYPE: begin
            hdr_q  <= hdr_t'(rx_data_i);
            sum_q  <= rx_data_i;
            left_q <= rx_data_i[LEN_W-1:0];
            st_q   <= R_ADDR;
          end
          R_ADDR: begin
            addr_q   <= rx_data_i;
            sum_q    <= sum_q + rx_data_i;
            strobe_q <= 1'b1;
            st_q     <= (left_q == '0) ? R_SUM : R_PAY;
          end
          R_PAY: begin
            sum_q  <= sum_q + rx_data_i;
            left_q <= left_q - 1'b1;
            if (left_q == LEN_W'(1)) st_q <= R_SUM;
          end
          R_SUM: begin
            if (hdr_q.chk_en && rx_data_i != sum_q) begin
              done_q <= 1'b1;
              serr_q <= 1'b1;
              st_q   <= R_HUNT;
            end else begin
              st_q <= R_TRL;
            end
          end
          R_TRL: begin
            done_q <= 1'b1;
            ferr_q <= (rx_data_i != TRL_KEY);
            st_q   <= R_HUNT;
          end
          default: st_q <= R_HUNT;
        endcase
      end
    end
  end

  // R8/R10: error flags only accompany completion
  p_err_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_err_o || frame_err_o) |-> done_o);

  // R10: one cause per completed frame
  p_err_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sum_err_o, frame_err_o}));

  // R7: header strobe is a single-cycle pulse
  p_strobe_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_strobe_o |=> !hdr_strobe_o);

  // R5: a stalled payload sink stalls the link
  p_backpressure_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pl_valid_o && !pl_ready_i) |-> !rx_ready_o);
endmodule

// File: rtl/pkt_link_codec.sv
module pkt_link_codec
  import pkt_pkg::*;
#(
  parameter logic [31:0] HDR_KEY = 32'hA5C3_0F1E,
  parameter logic [31:0] TRL_KEY = 32'hE1F0_3C5A
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] tx_hdr_i,
  input  logic [31:0] tx_addr_i,
  input  logic        tx_hdr_valid_i,
  output logic        tx_hdr_ready_o,
  input  logic [31:0] tx_pl_data_i,
  input  logic        tx_pl_valid_i,
  output logic        tx_pl_ready_o,
  output logic [31:0] link_tx_data_o,
  output logic        link_tx_valid_o,
  input  logic        link_tx_ready_i,
  input  logic [31:0] link_rx_data_i,
  input  logic        link_rx_valid_i,
  output logic        link_rx_ready_o,
  output logic [31:0] rx_hdr_o,
  output logic [31:0] rx_addr_o,
  output logic        rx_hdr_strobe_o,
  output logic [31:0] rx_pl_data_o,
  output logic        rx_pl_valid_o,
  input  logic        rx_pl_ready_i,
  output logic        rx_done_o,
  output logic        rx_sum_err_o,
  output logic        rx_frame_err_o
);
  pkt_tx #(.HDR_KEY(HDR_KEY), .TRL_KEY(TRL_KEY)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hdr_i       (tx_hdr_i),
    .addr_i      (tx_addr_i),
    .hdr_valid_i (tx_hdr_valid_i),
    .hdr_ready_o (tx_hdr_ready_o),
    .pl_data_i   (tx_pl_data_i),
    .pl_valid_i  (tx_pl_valid_i),
    .pl_ready_o  (tx_pl_ready_o),
    .tx_data_o   (link_tx_data_o),
    .tx_valid_o  (link_tx_valid_o),
    .tx_ready_i  (link_tx_ready_i)
  );

  pkt_rx #(.HDR_KEY(HDR_KEY), .TRL_KEY(TRL_KEY)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_data_i    (link_rx_data_i),
    .rx_valid_i   (link_rx_valid_i),
    .rx_ready_o   (link_rx_ready_o),
    .hdr_o        (rx_hdr_o),
    .addr_o       (rx_addr_o),
    .hdr_strobe_o (rx_hdr_strobe_o),
    .pl_data_o    (rx_pl_data_o),
    .pl_valid_o   (rx_pl_valid_o),
    .pl_ready_i   (rx_pl_ready_i),
    .done_o       (rx_done_o),
    .sum_err_o    (rx_sum_err_o),
    .frame_err_o  (rx_frame_err_o)
  );
endmodule

// File: tb/pkt_link_codec_tb_top.sv
module pkt_link_codec_tb_top;
  localparam logic [31:0] HK = 32'hA5C3_0F1E;
  localparam logic [31:0] TK = 32'hE1F0_3C5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] tx_hdr, tx_addr, tx_pl_data, link_tx_data, link_rx_data;
  logic [31:0] rx_hdr, rx_addr, rx_pl_data;
  logic tx_hdr_valid, tx_hdr_ready, tx_pl_valid, tx_pl_ready;
  logic link_tx_valid, link_tx_ready, link_rx_valid, link_rx_ready;
  logic rx_hdr_strobe, rx_pl_valid, rx_pl_ready, rx_done, rx_sum_err, rx_frame_err;

  pkt_link_codec dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_hdr_i(tx_hdr), .tx_addr_i(tx_addr), .tx_hdr_valid_i(tx_hdr_valid),
    .tx_hdr_ready_o(tx_hdr_ready), .tx_pl_data_i(tx_pl_data), .tx_pl_valid_i(tx_pl_valid),
    .tx_pl_ready_o(tx_pl_ready), .link_tx_data_o(link_tx_data), .link_tx_valid_o(link_tx_valid),
    .link_tx_ready_i(link_tx_ready), .link_rx_data_i(link_rx_data), .link_rx_valid_i(link_rx_valid),
    .link_rx_ready_o(link_rx_ready), .rx_hdr_o(rx_hdr), .rx_addr_o(rx_addr),
    .rx_hdr_strobe_o(rx_hdr_strobe), .rx_pl_data_o(rx_pl_data), .rx_pl_valid_o(rx_pl_valid),
    .rx_pl_ready_i(rx_pl_ready), .rx_done_o(rx_done), .rx_sum_err_o(rx_sum_err),
    .rx_frame_err_o(rx_frame_err)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] exp_tx[$];
  string       exp_tag[$];
  logic [31:0] exp_pl[$], exp_hdr[$], exp_addr[$];
  logic [1:0]  exp_res[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // R3 field layout
  function automatic logic [31:0] mk_hdr(input logic [1:0] kind, input logic [1:0] prio,
      input logic [3:0] src, input logic [3:0] dst, input bit chk_en,
      input logic [1:0] x, input logic [1:0] y, input logic [7:0] len);
    return {kind, prio, src, dst, 2'd1, 2'd2, 2'd3, 1'b1, chk_en, x, y, len};
  endfunction

  function automatic logic [31:0] pl_word(input logic [31:0] seed, input int i);
    return seed ^ (32'(i) * 32'h9E37_79B9);
  endfunction

  // stall patterns
  logic [7:0] lfsr = 8'hE1;
  always @(negedge clk) begin
    lfsr          <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    link_tx_ready <= lfsr[0] | lfsr[3];
    rx_pl_ready   <= lfsr[1] | lfsr[6];
  end

  task automatic tx_send(input logic [31:0] h, input logic [31:0] a, input int n, input logic [31:0] seed);
    logic [31:0] s;
    s = h + a;
    exp_tx.push_back(HK);  exp_tag.push_back("R1 start keyword");
    exp_tx.push_back(h);   exp_tag.push_back("R3 header word");
    exp_tx.push_back(a);   exp_tag.push_back("R1 address word");
    for (int i = 0; i < n; i++) begin
      exp_tx.push_back(pl_word(seed, i)); exp_tag.push_back("R1 payload word");
      s += pl_word(seed, i);
    end
    exp_tx.push_back(s);
    exp_tag.push_back(n == 0 ? "R4 checksum right after address" : "R2 checksum word");
    exp_tx.push_back(TK);  exp_tag.push_back("R1 end keyword");
    tx_hdr = h; tx_addr = a; tx_hdr_valid = 1'b1;
    #8;
    while (!tx_hdr_ready) begin @(negedge clk); #8; end
    @(negedge clk);
    tx_hdr_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      tx_pl_data = pl_word(seed, i); tx_pl_valid = 1'b1;
      #8;
      while (!tx_pl_ready) begin @(negedge clk); #8; end
      @(negedge clk);
      tx_pl_valid = 1'b0;
      if (i % 3 == 2) @(negedge clk);
    end
    while (exp_tx.size() != 0) @(negedge clk);
  endtask

  task automatic rx_pkt(input logic [31:0] h, input logic [31:0] a, input int n, input logic [31:0] seed,
      input int junk, input logic [31:0] sum_bad, input bit trl_bad);
    logic [31:0] w[$];
    logic [31:0] s;
    for (int i = 0; i < junk; i++) w.push_back(32'h0BAD_0000 + 32'(i));
    w.push_back(HK); w.push_back(h); w.push_back(a);
    s = h + a;
    exp_hdr.push_back(h); exp_addr.push_back(a);
    for (int i = 0; i < n; i++) begin
      w.push_back(pl_word(seed, i));
      s += pl_word(seed, i);
      exp_pl.push_back(pl_word(seed, i));
    end
    w.push_back(s + sum_bad);
    w.push_back(trl_bad ? ~TK : TK);
    if (sum_bad != 0 && h[12]) exp_res.push_back(2'b10);
    else exp_res.push_back({1'b0, trl_bad});
    foreach (w[k]) begin
      link_rx_data = w[k]; link_rx_valid = 1'b1;
      #8;
      while (!link_rx_ready) begin @(negedge clk); #8; end
      @(negedge clk);
      link_rx_valid = 1'b0;
      if (k % 4 == 3) @(negedge clk);
    end
  endtask

  // per-clock reference comparison
  logic [31:0] hold_w;
  bit          hold_v = 0;
  always @(negedge clk) begin
    logic [31:0] e;
    string t;
    if (rst_n && !finished) begin
      #8;
      if (hold_v)
        chk(link_tx_valid && link_tx_data == hold_w, "R5 link word held under stall", link_tx_data, hold_w);
      hold_v = link_tx_valid && !link_tx_ready;
      hold_w = link_tx_data;
      if (link_tx_valid && link_tx_ready) begin
        if (exp_tx.size() == 0) chk(0, "R1 unexpected link word", link_tx_data, 32'h0);
        else begin
          e = exp_tx.pop_front();
          t = exp_tag.pop_front();
          chk(link_tx_data == e, t, link_tx_data, e);
        end
      end
      if (rx_pl_valid && !rx_pl_ready)
        chk(!link_rx_ready, "R5 rx payload backpressure", 32'(link_rx_ready), 32'h0);
      if (rx_pl_valid && rx_pl_ready) begin
        if (exp_pl.size() == 0) chk(0, "R6 output from discarded word", rx_pl_data, 32'h0);
        else begin
          e = exp_pl.pop_front();
          chk(rx_pl_data == e, "R7 payload order", rx_pl_data, e);
        end
      end
      if (rx_hdr_strobe) begin
        if (exp_hdr.size() == 0) chk(0, "R6 strobe without frame", rx_hdr, 32'h0);
        else begin
          e = exp_hdr.pop_front();
          chk(rx_hdr == e, "R7 header capture", rx_hdr, e);
          e = exp_addr.pop_front();
          chk(rx_addr == e, "R7 address capture", rx_addr, e);
        end
      end
      if ((rx_sum_err || rx_frame_err) && !rx_done)
        chk(0, "R8 error flag without done", {30'd0, rx_sum_err, rx_frame_err}, 32'h0);
      if (rx_done) begin
        if (exp_res.size() == 0) chk(0, "R10 unexpected done", 32'h1, 32'h0);
        else begin
          e = {30'd0, exp_res.pop_front()};
          chk({30'd0, rx_sum_err, rx_frame_err} == e, "R8/R9/R10 completion flags {sum,frame}",
              {30'd0, rx_sum_err, rx_frame_err}, e);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    chk(0, "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    tx_hdr = '0; tx_addr = '0; tx_hdr_valid = 0; tx_pl_data = '0; tx_pl_valid = 0;
    link_rx_data = '0; link_rx_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #8;
    // R11 reset state
    chk(!link_tx_valid, "R11 link output idle", 32'(link_tx_valid), 32'h0);
    chk(tx_hdr_ready, "R11 header accepted", 32'(tx_hdr_ready), 32'h1);
    chk(link_rx_ready, "R11 link input accepted", 32'(link_rx_ready), 32'h1);
    chk(!rx_done && !rx_hdr_strobe && !rx_pl_valid, "R11 no receive activity",
        {29'd0, rx_done, rx_hdr_strobe, rx_pl_valid}, 32'h0);
    @(negedge clk);
    fork
      begin
        tx_send(mk_hdr(2'd0, 2'd1, 4'h3, 4'h9, 1'b1, 2'd0, 2'd1, 8'd5), 32'h0004_F00C, 5, 32'h1234_5678);
        tx_send(mk_hdr(2'd2, 2'd3, 4'h9, 4'h3, 1'b1, 2'd1, 2'd1, 8'd0), 32'h0000_00AC, 0, 32'h0);
        tx_send(mk_hdr(2'd1, 2'd0, 4'h1, 4'h2, 1'b0, 2'd0, 2'd0, 8'd5), 32'hFFFF_4004, 5, 32'hAAAA_F003);
        tx_send(mk_hdr(2'd0, 2'd2, 4'hF, 4'h0, 1'b1, 2'd2, 2'd3, 8'd12), 32'h8000_0000, 12, 32'hFFFF_FFF0);
      end
      begin
        // R6 junk before a clean frame
        rx_pkt(mk_hdr(2'd0, 2'd1, 4'h5, 4'h6, 1'b1, 2'd0, 2'd1, 8'd4), 32'h0002_F00B, 4, 32'hCAFE_0001, 3, 32'h0, 1'b0);
        // R8 bad checksum, then clean frame shows return to search
        rx_pkt(mk_hdr(2'd0, 2'd0, 4'h1, 4'h7, 1'b1, 2'd1, 2'd2, 8'd1), 32'h0000_1000, 1, 32'h0BEE_F00D, 0, 32'h1, 1'b0);
        rx_pkt(mk_hdr(2'd2, 2'd0, 4'h7, 4'h1, 1'b1, 2'd0, 2'd1, 8'd0), 32'h0000_2000, 0, 32'h0, 0, 32'h0, 1'b0);
        // R9 check disabled ignores a wrong checksum
        rx_pkt(mk_hdr(2'd1, 2'd3, 4'h2, 4'h8, 1'b0, 2'd0, 2'd1, 8'd5), 32'h0000_3000, 5, 32'h5555_AAAA, 1, 32'h10, 1'b0);
        // R10 wrong end keyword
        rx_pkt(mk_hdr(2'd0, 2'd1, 4'h4, 4'h4, 1'b1, 2'd0, 2'd1, 8'd12), 32'h0000_4000, 12, 32'h0F0F_0F0F, 2, 32'h0, 1'b1);
        rx_pkt(mk_hdr(2'd0, 2'd1, 4'h4, 4'h5, 1'b1, 2'd0, 2'd1, 8'd2), 32'h0000_5000, 2, 32'h7777_0000, 0, 32'h0, 1'b0);
      end
    join
    repeat (10) @(negedge clk);
    #8;
    chk(exp_tx.size() == 0, "R1 all link words sent", 32'(exp_tx.size()), 32'h0);
    chk(exp_pl.size() == 0, "R7 all payload forwarded", 32'(exp_pl.size()), 32'h0);
    chk(exp_hdr.size() == 0, "R7 all headers strobed", 32'(exp_hdr.size()), 32'h0);
    chk(exp_res.size() == 0, "R10 all frames completed", 32'(exp_res.size()), 32'h0);
    finish_run();
  end
endmodule